// File: doc/BRIEF.md
# Power-of-two clock prescaler with aligned ratio switching

The block divides a main clock by a power of two between 1 and 128 and drives one divided clock per clock domain (two by default). Each domain has a divide register that takes its ratio as a one-hot code. Register 0 can be locked by a protection input. A single free-running phase counter clocked by the main clock supplies every divided phase, so all possible divided clocks stay aligned to one another.

When a valid code is written, the register reads back the new value at once, but the domain clock keeps its old ratio. The new ratio is applied at the first main-clock edge where both the old and the new divided clock fall together. A sticky ready flag then reports that a switch has been made, and software clears it by writing a one.

Software must keep the ratio of domain 0 below that of domain 1. The block does not enforce this rule. Invalid codes and protected writes leave all state untouched.

Top module: `pow2_clk_prescaler`

## Requirements
- R1: A code with only bit k set (k = 1..7, code 0x02..0x80) divides by 2^k. When it is active, the domain clock equals bit k-1 of the count of main-clock rising edges since reset release, taken modulo 128, and it changes only at those rising edges.
- R2: When a domain runs at divide by 1 (code 0x01), its clock output follows the main clock.
- R3: While reset is low and right after it is released: register 0 reads 0x00, register 1 reads 0x01, the ready flag is 0, and both domains run at divide by 1. A value of 0x00 in register 0 counts as divide by 1.
- R4: Reads are combinational. Address 0 returns register 0, address 1 returns register 1, address 2 returns the ready flag in bit 0 with all other bits zero, and address 3 returns zero.
- R5: A valid write is visible on reads from the next cycle. The domain clock keeps its previous ratio until the switch edge.
- R6: Let the write be captured at rising edge c, and let m be the larger exponent of the active ratio and the pending ratio. The switch happens at the first rising edge e > c whose edge count is a multiple of 2^m. If both ratios are divide by 1, that is edge c+1.
- R7: The ready flag reads 1 from the switch edge onward, until it is cleared.
- R8: Writing to address 2 with bit 0 set clears the flag. Bit 0 clear has no effect. A switch on the same edge takes priority over the clear.
- R9: A write whose data is not one-hot (including 0x00) is ignored. The register keeps its value, no switch follows and the flag is not set.
- R10: A write to address 0 while wprot_i is high is ignored. Address 1 is never protected.
- R11: A valid write made before the pending ratio has been applied replaces it. The earlier ratio is never applied, and the flag is set when the newest ratio takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Main clock to be divided |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address: 0, 1 divide registers, 2 flag |
| wr_data_i | input | 8 | Write data, one-hot ratio or flag clear mask |
| wprot_i | input | 1 | Locks writes to divide register 0 while high |
| rd_addr_i | input | 2 | Read address |
| rd_data_o | output | 8 | Read data |
| clk_div_o | output | 2 | Divided clock per domain |
| div_rdy_o | output | 1 | Sticky ratio-switch-done flag |

## Verification
The bench builds the block with its defaults: an 8-bit code, which gives ratios 1 to 128, and two domains. This size exercises the full ratio range, including divide by 128. At that ratio the alignment condition needs the 7-bit phase counter to wrap. Two domains also bring within reach the contrast between the protected register and the free one. The bench also covers switches in both directions between divide by 1 and counter-driven ratios, and a pending ratio that is overwritten before it lands.

// File: rtl/clk_presc_pkg.sv
package clk_presc_pkg;

  // index of the highest set bit; callers pass one-hot codes
  function automatic int unsigned oh_to_idx(input logic [31:0] code);
    int unsigned idx;
    idx = 0;
    for (int unsigned i = 0; i < 32; i++) begin
      if (code[i]) idx = i;
    end
    return idx;
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/clk_presc_phase.sv
module clk_presc_phase #(
  parameter int unsigned CNT_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] cnt_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_o <= '0;
    else         cnt_o <= cnt_o + CNT_W'(1);
  end

endmodule

// File: rtl/clk_presc_regs.sv
module clk_presc_regs import clk_presc_pkg::*; #(
  parameter int unsigned DIV_W   = 8,
  parameter int unsigned NUM_DOM = 2,
  parameter int unsigned ADDR_W  = 2,
  parameter int unsigned IDX_W   = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [DIV_W-1:0]   wr_data_i,
  input  logic               wprot_i,
  input  logic [ADDR_W-1:0]  rd_addr_i,
  input  logic               set_i,
  output logic [DIV_W-1:0]   rd_data_o,
  output logic [NUM_DOM-1:0] load_o,
  output logic [IDX_W-1:0]   load_idx_o,
  output logic               flag_o
);

  localparam logic [ADDR_W-1:0] FLAG_ADDR = ADDR_W'(NUM_DOM);

  logic [NUM_DOM-1:0][DIV_W-1:0] div_q;
  logic code_ok, clr, flag_q;

  function automatic logic [DIV_W-1:0] rst_val(input int unsigned d);
    return (d == 0) ? '0 : DIV_W'(1);
  endfunction

  assign code_ok    = $onehot(wr_data_i);
  assign clr        = wr_en_i && (wr_addr_i == FLAG_ADDR) && wr_data_i[0];
  assign load_idx_o = IDX_W'(oh_to_idx(32'(wr_data_i)));
  assign flag_o     = flag_q;

  always_comb begin
    for (int unsigned d = 0; d < NUM_DOM; d++) begin
      load_o[d] = wr_en_i && code_ok && (wr_addr_i == ADDR_W'(d)) && !((d == 0) && wprot_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int unsigned d = 0; d < NUM_DOM; d++) div_q[d] <= rst_val(d);
    end else begin
      for (int unsigned d = 0; d < NUM_DOM; d++) begin
        if (load_o[d]) div_q[d] <= wr_data_i;
      end
    end
  end

  // set wins over a same-edge clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;
    else if (clr)   flag_q <= 1'b0;
  end

  always_comb begin
    rd_data_o = '0;
    for (int unsigned d = 0; d < NUM_DOM; d++) begin
      if (rd_addr_i == ADDR_W'(d)) rd_data_o = div_q[d];
    end
    if (rd_addr_i == FLAG_ADDR) rd_data_o = {{(DIV_W-1){1'b0}}, flag_q};
  end

  a_r9_bad_code_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !$onehot(wr_data_i)) |=> $stable(div_q));

  a_r10_protected_reg0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wprot_i && (wr_addr_i == '0)) |=> $stable(div_q[0]));

  a_r7_flag_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_q);

  a_r8_flag_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr && !set_i) |=> !flag_q);

  a_r1_regs_onehot0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(div_q[0]) && $onehot(div_q[NUM_DOM-1]));

endmodule

// File: rtl/clk_presc_switch.sv
module clk_presc_switch import clk_presc_pkg::*; #(
  parameter int unsigned DIV_W = 8,
  parameter int unsigned CNT_W = 7,
  parameter int unsigned IDX_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             load_i,
  input  logic [IDX_W-1:0] load_idx_i,
  output logic             clk_o,
  output logic             applied_o
);

  logic [IDX_W-1:0] act_q, pend_idx_q;
  logic             pend_q;
  logic [IDX_W-1:0] span;
  logic [CNT_W-1:0] mask;
  logic             aligned, div_bit;

  // both clocks fall on the edge that zeroes the low span counter bits
  always_comb begin
    span = IDX_W'(max_u(32'(act_q), 32'(pend_idx_q)));
    for (int unsigned i = 0; i < CNT_W; i++) mask[i] = (i < 32'(span));
  end

  assign aligned   = &(cnt_i | ~mask);
  assign applied_o = pend_q && aligned;

  always_comb begin
    div_bit = 1'b0;
    for (int unsigned i = 1; i < DIV_W; i++) begin
      if (act_q == IDX_W'(i)) div_bit = cnt_i[i-1];
    end
  end

  assign clk_o = (act_q == '0) ? clk_i : div_bit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q      <= '0;
      pend_idx_q <= '0;
      pend_q     <= 1'b0;
    end else begin
      if (applied_o) act_q <= pend_idx_q;
      if (load_i) begin
        pend_q     <= 1'b1;
        pend_idx_q <= load_idx_i;
      end else if (applied_o) begin
        pend_q <= 1'b0;
      end
    end
  end

  a_r5_hold_ratio: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pend_q |=> $stable(act_q));

  a_r6_lands_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(act_q) && (act_q != '0)) |-> !clk_o);

  a_r11_pending_retired: assert property (@(posedge clk_i) disable iff (!rst_ni)
    applied_o |=> (!pend_q || $past(load_i)));

endmodule

// File: rtl/pow2_clk_prescaler.sv
module pow2_clk_prescaler #(
  parameter int unsigned DIV_W   = 8,
  parameter int unsigned NUM_DOM = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_en_i,
  input  logic [$clog2(NUM_DOM+1)-1:0]  wr_addr_i,
  input  logic [DIV_W-1:0]              wr_data_i,
  input  logic                          wprot_i,
  input  logic [$clog2(NUM_DOM+1)-1:0]  rd_addr_i,
  output logic [DIV_W-1:0]              rd_data_o,
  output logic [NUM_DOM-1:0]            clk_div_o,
  output logic                          div_rdy_o
);

  localparam int unsigned CNT_W  = DIV_W - 1;
  localparam int unsigned IDX_W  = $clog2(DIV_W);
  localparam int unsigned ADDR_W = $clog2(NUM_DOM + 1);

  logic [CNT_W-1:0]   cnt;
  logic [NUM_DOM-1:0] load, applied;
  logic [IDX_W-1:0]   load_idx;

  clk_presc_phase #(.CNT_W(CNT_W)) i_phase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cnt_o  (cnt)
  );

  clk_presc_regs #(
    .DIV_W(DIV_W), .NUM_DOM(NUM_DOM), .ADDR_W(ADDR_W), .IDX_W(IDX_W)
  ) i_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .wprot_i    (wprot_i),
    .rd_addr_i  (rd_addr_i),
    .set_i      (|applied),
    .rd_data_o  (rd_data_o),
    .load_o     (load),
    .load_idx_o (load_idx),
    .flag_o     (div_rdy_o)
  );

  for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
    clk_presc_switch #(.DIV_W(DIV_W), .CNT_W(CNT_W), .IDX_W(IDX_W)) i_switch (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .cnt_i      (cnt),
      .load_i     (load[d]),
      .load_idx_i (load_idx),
      .clk_o      (clk_div_o[d]),
      .applied_o  (applied[d])
    );
  end

endmodule

// File: tb/test_pow2_clk_prescaler.sv
module test_pow2_clk_prescaler;

  typedef struct {
    int addr;
    int data;
    bit prot;
  } wr_t;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [1:0] wr_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic       wprot_i = 1'b0;
  logic [1:0] rd_addr_i = '0;
  logic [7:0] rd_data_o;
  logic [1:0] clk_div_o;
  logic       div_rdy_o;

  int    n_chk = 0, n_fail = 0;
  string tag = "R3";
  wr_t   wq[$];

  // reference state
  int act_k[2], pend_k[2], regs[2];
  bit pend_v[2], just_sw[2];
  bit rdy_m = 0;
  int cyc = 0;

  pow2_clk_prescaler i_pow2_clk_prescaler (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i, .wprot_i,
    .rd_addr_i, .rd_data_o, .clk_div_o, .div_rdy_o
  );

  always #10 clk_i = ~clk_i;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s (phase %s) cyc %0d: got %0h expected %0h", req, tag, cyc, act, exp);
    end
  endtask

  function automatic bit is_oh(int v);
    return (v > 0) && (v < 256) && ((v & (v - 1)) == 0);
  endfunction

  function automatic int oh_idx(int v);
    int r = 0;
    for (int i = 0; i < 8; i++) if (v[i]) r = i;
    return r;
  endfunction

  function automatic bit exp_clk(int d, bit hi);
    if (act_k[d] == 0) return hi;
    return bit'((cyc >> (act_k[d] - 1)) & 1);
  endfunction

  function automatic string clk_tag(int d);
    if (just_sw[d]) return "R6";
    if (pend_v[d]) return "R5";
    return (act_k[d] == 0) ? "R2" : "R1";
  endfunction

  task automatic wr(int addr, int data, bit prot);
    wr_t it;
    @(negedge clk_i);
    it.addr = addr; it.data = data; it.prot = prot;
    wq.push_back(it);
    wr_en_i = 1'b1; wr_addr_i = 2'(addr); wr_data_i = 8'(data); wprot_i = prot;
    @(negedge clk_i);
    wr_en_i = 1'b0; wprot_i = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // read address sweep
  initial forever begin
    @(negedge clk_i);
    rd_addr_i = rd_addr_i + 2'd1;
  end

  // monitor / scoreboard
  initial begin
    wr_t it;
    bit  setn;
    int  m, a;
    logic [31:0] exp_rd;
    regs[0] = 0; regs[1] = 1;
    act_k[0] = 0; act_k[1] = 0; pend_v[0] = 0; pend_v[1] = 0;
    wait (rst_ni === 1'b1);
    forever begin
      @(posedge clk_i);
      #1;
      cyc++;
      setn = 0;
      for (int d = 0; d < 2; d++) begin
        just_sw[d] = 0;
        if (pend_v[d]) begin
          m = (act_k[d] > pend_k[d]) ? act_k[d] : pend_k[d];
          if ((cyc % (1 << m)) == 0) begin
            act_k[d] = pend_k[d]; pend_v[d] = 0; rdy_m = 1; setn = 1; just_sw[d] = 1;
          end
        end
      end
      if (wr_en_i === 1'b1) begin
        if (wq.size() == 0) chk("R4", 1, 0);
        else begin
          it = wq.pop_front();
          if (it.addr < 2) begin
            if (!(it.addr == 0 && it.prot) && is_oh(it.data)) begin
              regs[it.addr] = it.data;
              pend_v[it.addr] = 1;
              pend_k[it.addr] = oh_idx(it.data);
            end
          end else if (it.addr == 2) begin
            if (it.data[0] && !setn) rdy_m = 0;
          end
        end
      end
      #4;
      for (int d = 0; d < 2; d++) chk(clk_tag(d), clk_div_o[d], exp_clk(d, 1));
      a = int'(rd_addr_i);
      exp_rd = (a < 2) ? regs[a] : (a == 2) ? 32'(rdy_m) : 0;
      chk((a == 2) ? "R8" : "R4", rd_data_o, exp_rd);
      chk("R7", div_rdy_o, rdy_m);
      #10;
      for (int d = 0; d < 2; d++) chk(clk_tag(d), clk_div_o[d], exp_clk(d, 0));
    end
  end

  // watchdog
  initial begin
    #(20 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired (all requirements)");
    finish_run();
  end

  // stimulus
  initial begin
    idle(3);
    // R3: reset values seen while reset is held
    tag = "R3";
    #5;
    chk("R3", div_rdy_o, 0);
    chk("R3", clk_div_o, 2'b00);
    rd_addr_i = 2'd0; #1; chk("R3", rd_data_o, 8'h00);
    rd_addr_i = 2'd1; #1; chk("R3", rd_data_o, 8'h01);
    @(negedge clk_i);
    rst_ni = 1'b1;
    idle(4);

    tag = "R6";
    wr(1, 8'h04, 0);  idle(20);

    tag = "R8";
    wr(2, 8'h00, 0);  idle(3);
    wr(2, 8'h01, 0);  idle(3);

    tag = "R10";
    wr(0, 8'h02, 1);  idle(6);
    wr(1, 8'h02, 1);  idle(10);
    wr(2, 8'h01, 0);
    wr(0, 8'h02, 0);  idle(10);

    tag = "R9";
    wr(2, 8'h01, 0);
    wr(1, 8'h03, 0);
    wr(1, 8'h00, 0);
    wr(0, 8'hff, 0);  idle(8);

    tag = "R11";
    wr(1, 8'h80, 0);  idle(2);
    wr(1, 8'h10, 0);  idle(40);
    wr(2, 8'h01, 0);  idle(140);

    tag = "R2";
    wr(1, 8'h01, 0);
    wr(0, 8'h01, 0);  idle(20);

    tag = "R1";
    wr(0, 8'h40, 0);
    wr(1, 8'h20, 0);  idle(140);
    wr(1, 8'h80, 0);  idle(140);
    wr(0, 8'h08, 0);  idle(70);
    wr(1, 8'h01, 0);  idle(140);

    idle(4);
    finish_run();
  end

endmodule